// File: doc/BRIEF.md
# EPROM Mode Decoder with Identifier

A synthesizable behavioural model of a byte-wide, erasable, write-once-per-bit read-only memory, meant to serve as a stand-in device in simulation or as a device under test. The block decodes four control flags: an active-low chip select, an active-low output gate, a flag that marks the programming supply as raised, and a flag that marks a high voltage on address bit 9. From these it picks one of seven operating modes: read, output disable, standby, program, program verify, program inhibit and identifier read. The bidirectional data pins are split into a data-in bus, a data-out bus and an output-drive enable. When the enable is low, the data-out bus is held at zero and stands for high impedance.

Cells start erased (all ones) after reset or a pulse on the erase input. Programming can only pull bits to zero: a program cycle stores the old byte ANDed with the new byte. The identifier mode returns a fixed manufacturer byte and a fixed device byte, each carrying odd parity in bit 7. The address width is a parameter. The default of 10 bits keeps elaboration small, and a width of 15 gives the full 32K×8 array. Analogue levels and access delays are not modelled. Reads are combinational, and writes and erases take effect at the rising clock edge.

Top module: `eprom_model`

## Requirements
- R1: After reset every byte reads FFh.
- R2: A cycle with erase high sets every byte to FFh at the clock edge, and it overrides a program operation in the same cycle.
- R3: With ce_n=0, oe_n=0 and vpp_hi=0 (and no identifier hit), dout_en=1 and dout is the stored byte at addr.
- R4: With vpp_hi=0 and either ce_n=1 (standby) or oe_n=1 (output disable), dout_en=0, dout=00h and no byte is written.
- R5: With ce_n=0, oe_n=1 and vpp_hi=1, the byte at addr becomes old AND din at the clock edge, and dout_en=0 during the cycle.
- R6: Programming cannot set a zero bit back to one. Programming a byte holding 00h with FFh leaves 00h.
- R7: With ce_n=0, oe_n=0 and vpp_hi=1 (program verify), dout_en=1, dout is the stored byte, and nothing is written.
- R8: With ce_n=1 and vpp_hi=1 (program inhibit), dout_en=0, dout=00h and nothing is written.
- R9: With ce_n=0, oe_n=0, vpp_hi=0, id_hv=1 and every address bit other than bits 0 and 9 at zero, dout is 01h when addr[0]=0 and 10h when addr[0]=1. The value of addr[9] does not matter.
- R10: Both identifier bytes hold an odd number of ones, and bit 7 is the parity bit over bits 6..0.
- R11: With id_hv=1 but any address bit other than bits 0 and 9 set, a read returns the stored byte as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and erases occur at its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; erases the array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply is raised |
| id_hv | input | 1 | High voltage present on address bit 9 |
| erase | input | 1 | Bulk erase request, all cells to one |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Data driven out; 00h when not driving |
| dout_en | output | 1 | Output drive enable (0 = high impedance) |

## Verification
On every cycle, the assertions check that the outputs float whenever standby or inhibit is decoded, and that a floated output reads zero. They also check that an identifier hit carries odd parity and that a program cycle never drives the bus. Further checks cover a verify that follows a program at the same address, which can show no bit that the programmed data did not allow, and a read after an erase, which sees FFh. The bench's sweeps are needed to show that every address holds exactly the ANDed value and that the no-write modes leave the whole array untouched. The sweeps also show that the identifier decode falls back to a normal read for each single stray address bit.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STBY    = 3'd0,
    MD_ODIS    = 3'd1,
    MD_READ    = 3'd2,
    MD_PROG    = 3'd3,
    MD_VERIFY  = 3'd4,
    MD_INHIBIT = 3'd5,
    MD_ID      = 3'd6
  } eprom_mode_e;

  // Identifier byte: bit 7 chosen so the whole byte has odd weight.
  function automatic logic [BYTE_W-1:0] id_with_parity(input logic [BYTE_W-2:0] low);
    return {~(^low), low};
  endfunction

  // Program semantics: bits only move from one to zero.
  function automatic logic [BYTE_W-1:0] burn(input logic [BYTE_W-1:0] old_v,
                                             input logic [BYTE_W-1:0] new_v);
    return old_v & new_v;
  endfunction
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int HV_BIT  = 9,
  parameter int SEL_BIT = 0
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  output eprom_mode_e       mode,
  output logic              id_sel
);
  // Address bits that must be zero for an identifier access.
  localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDLE_MSK = ~((ONE_A << HV_BIT) | (ONE_A << SEL_BIT));

  logic others_low;
  assign others_low = ((addr & IDLE_MSK) == '0);
  assign id_sel     = addr[SEL_BIT];

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STBY;
    end else if (vpp_hi) begin
      mode = oe_n ? MD_PROG : MD_VERIFY;
    end else if (oe_n) begin
      mode = MD_ODIS;
    end else if (id_hv && others_low) begin
      mode = MD_ID;
    end else begin
      mode = MD_READ;
    end
  end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[addr] <= burn(cells[addr], wr_data);
    end
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux
  import eprom_pkg::*;
#(
  parameter logic [BYTE_W-2:0] MFR_LOW = 7'h01,
  parameter logic [BYTE_W-2:0] DEV_LOW = 7'h10
) (
  input  eprom_mode_e       mode,
  input  logic              id_sel,
  input  logic [BYTE_W-1:0] cell_q,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en
);
  localparam logic [BYTE_W-1:0] MFR_BYTE = id_with_parity(MFR_LOW);
  localparam logic [BYTE_W-1:0] DEV_BYTE = id_with_parity(DEV_LOW);

  always_comb begin
    dout    = '0;
    dout_en = 1'b0;
    unique case (mode)
      MD_READ, MD_VERIFY: begin
        dout    = cell_q;
        dout_en = 1'b1;
      end
      MD_ID: begin
        dout    = id_sel ? DEV_BYTE : MFR_BYTE;
        dout_en = 1'b1;
      end
      default: begin
        dout    = '0;
        dout_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int HV_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  eprom_mode_e       mode;
  logic              id_sel;
  logic [BYTE_W-1:0] cell_q;

  // Named internal events for the checker.
  logic wr_fire;
  logic id_hit;

  eprom_mode_dec #(.ADDR_W(ADDR_W), .HV_BIT(HV_BIT), .SEL_BIT(0)) u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .id_hv  (id_hv),
    .addr   (addr),
    .mode   (mode),
    .id_sel (id_sel)
  );

  assign wr_fire = rst_n && !erase && (mode == MD_PROG);
  assign id_hit  = (mode == MD_ID);

  eprom_cell_array #(.ADDR_W(ADDR_W)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase   (erase),
    .wr_en   (wr_fire),
    .addr    (addr),
    .wr_data (din),
    .rd_data (cell_q)
  );

  eprom_out_mux u_mux (
    .mode    (mode),
    .id_sel  (id_sel),
    .cell_q  (cell_q),
    .dout    (dout),
    .dout_en (dout_en)
  );
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              erase,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        din,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              wr_fire,
  input logic              id_hit
);
  p_float_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == 8'h00);

  p_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> !dout_en);

  p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_hi) |-> (!dout_en && !wr_fire));

  p_prog_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !dout_en);

  p_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |-> dout_en);

  p_id_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> ($countones(dout) % 2 == 1));

  p_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_fire) && !ce_n && !oe_n && vpp_hi && addr == $past(addr))
      |-> ((dout & ~$past(din)) == 8'h00));

  p_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(erase) && !ce_n && !oe_n && !id_hit) |-> dout == 8'hFF);
endmodule

bind eprom_model eprom_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .vpp_hi  (vpp_hi),
  .erase   (erase),
  .addr    (addr),
  .din     (din),
  .dout    (dout),
  .dout_en (dout_en),
  .wr_fire (wr_fire),
  .id_hit  (id_hit)
);

// File: tb/tb_eprom_model.sv
module tb_eprom_model;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_mem [DEPTH];

  always #4 clk = ~clk;

  eprom_model #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .erase(erase), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", req, addr, act, exp);
    end
  endtask

  // Set controls on the falling edge and let combinational outputs settle.
  task automatic drive(input logic c, input logic o, input logic v, input logic h,
                       input logic [AW-1:0] a, input logic [7:0] d, input logic e);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; id_hv = h; addr = a; din = d; erase = e;
    #1;
  endtask

  task automatic sweep_read(input string req, input logic verify);
    for (int a = 0; a < DEPTH; a++) begin
      drive(1'b0, 1'b0, verify, 1'b0, AW'(a), 8'h00, 1'b0);
      chk(req, {dout_en, dout}, {1'b1, exp_mem[a]});
    end
  endtask

  task automatic program_all(input int mul, input int add);
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d;
      d = 8'((a * mul + add) ^ (a >> 3));
      drive(1'b0, 1'b1, 1'b1, 1'b0, AW'(a), d, 1'b0);
      exp_mem[a] = exp_mem[a] & d;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: blank after reset
    sweep_read("R1", 1'b0);

    // R5: program sweep, bus floats while programming
    drive(1'b0, 1'b1, 1'b1, 1'b0, AW'(5), 8'hFF, 1'b0);
    chk("R5 float", {dout_en, dout}, 9'h000);
    program_all(37, 5);
    sweep_read("R5", 1'b1);          // R7: verify mode shows stored data
    sweep_read("R3", 1'b0);

    // R6: second pass can only clear bits
    program_all(11, 90);
    sweep_read("R6", 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, AW'(7), 8'h00, 1'b0);
    exp_mem[7] = 8'h00;
    drive(1'b0, 1'b1, 1'b1, 1'b0, AW'(7), 8'hFF, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, AW'(7), 8'h00, 1'b0);
    chk("R6 zero stays", {dout_en, dout}, {1'b1, 8'h00});

    // R4: standby and output disable float and do not write
    for (int a = 0; a < DEPTH; a += 97) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, AW'(a), 8'h00, 1'b0);
      chk("R4 standby", {dout_en, dout}, 9'h000);
      drive(1'b0, 1'b1, 1'b0, 1'b0, AW'(a), 8'h00, 1'b0);
      chk("R4 disable", {dout_en, dout}, 9'h000);
    end
    // R8: inhibit floats and does not write
    for (int a = 0; a < DEPTH; a += 61) begin
      drive(1'b1, 1'b1, 1'b1, 1'b0, AW'(a), 8'h00, 1'b0);
      chk("R8 inhibit", {dout_en, dout}, 9'h000);
      drive(1'b1, 1'b0, 1'b1, 1'b0, AW'(a), 8'h00, 1'b0);
      chk("R8 inhibit", {dout_en, dout}, 9'h000);
    end
    sweep_read("R4 R8 unchanged", 1'b0);

    // R9 / R10: identifier bytes, addr[9] irrelevant
    for (int hi = 0; hi < 2; hi++) begin
      for (int s = 0; s < 2; s++) begin
        logic [AW-1:0] a;
        a = AW'(s) | (hi != 0 ? AW'(1) << 9 : AW'(0));
        drive(1'b0, 1'b0, 1'b0, 1'b1, a, 8'h00, 1'b0);
        chk("R9 id", {dout_en, dout}, {1'b1, (s != 0) ? 8'h10 : 8'h01});
        chk("R10 odd weight", 9'($countones(dout) & 1), 9'd1);
        chk("R10 parity bit", 9'(dout[7]), 9'(($countones(dout[6:0]) + 1) & 1));
      end
    end

    // R11: any stray address bit falls back to normal read
    for (int k = 1; k < AW; k++) begin
      if (k != 9) begin
        for (int s = 0; s < 2; s++) begin
          logic [AW-1:0] a;
          a = (AW'(1) << k) | AW'(s);
          drive(1'b0, 1'b0, 1'b0, 1'b1, a, 8'h00, 1'b0);
          chk("R11 stray bit", {dout_en, dout}, {1'b1, exp_mem[a]});
        end
      end
    end

    // R2: erase wins over program in the same cycle
    drive(1'b0, 1'b1, 1'b1, 1'b0, AW'(3), 8'h00, 1'b1);
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    sweep_read("R2", 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule